// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block is a read-only, four-way set-associative instruction cache controller with 16-byte lines. It answers CPU fetch requests from its tag, valid and line arrays. When a fetch misses, it issues a line-aligned refill request on a simple memory port and installs the returned 128-bit line. Every line is either valid or invalid. The CPU never writes into the cache, so there is no modified state.

Software steers the cache through two paths. The first is a control-register write, which can start an invalidate of the whole cache and sets or clears a lock mode. The second is a set of line commands. A touch command preloads a line exactly as a miss would, but returns no data. A push command either leaves the line alone or, with its invalidate variant, drops the line.

The intended use of the lock is as follows. Invalidate the cache, then touch a region half the size of the cache so that it lands in ways 0 and 1, then set the lock. From then on, misses allocate only into ways 2 and 3, and the preloaded half stays resident.

Top module: `icache_ctrl`

## Requirements
- R1: A fetch that hits asserts `rsp_valid` in the cycle after the request is accepted. `rsp_data` then carries word k of the line, where k is address bits [3:2] and word k occupies line bits [32k+31:32k].
- R2: A fetch that misses raises `mem_req` with `mem_addr` equal to the fetch address with bits [3:0] cleared. `mem_req` and `mem_addr` are held until `mem_ack`. The word is returned in the cycle after the acknowledge, and the line then hits.
- R3: A touch command (`cmd_op` = 2'b01) to an absent line performs one refill and never asserts `rsp_valid`. A touch to a present line performs no refill. The touched line then hits.
- R4: A push-with-invalidate command (`cmd_op` = 2'b11) leaves the addressed line invalid, so the next fetch to it misses. A plain push (`cmd_op` = 2'b10) leaves a present line present.
- R5: A control write with bit 8 set walks one set per clock. `busy` is high for exactly one cycle per set and `cpu_ready` is low during the walk. Afterwards every line is invalid.
- R6: Every control write loads the lock mode from bit 11. A control write with bit 8 clear does not assert `busy`. Clearing the lock lets all four ways of a set hold lines again.
- R7: A miss fills the lowest-numbered invalid way among the allowed ways. If no allowed way is invalid, it uses a round-robin pointer that advances only on such replacements and that an invalidate-all resets to way 0.
- R8: While lock mode is set, refills go only into ways 2 and 3. Lines in ways 0 and 1 are never replaced, and an empty way 0 or 1 is not filled.
- R9: After reset no line is valid, `cpu_ready` is high, and `busy`, `mem_req` and `rsp_valid` are low.
- R10: When a control write, a line command and a fetch are offered in the same cycle, the control write is taken first, then the line command, then the fetch. Only one of them is accepted per cycle, and all three are accepted only while `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Fetch request |
| cpu_addr | input | ADDR_W | Fetch byte address |
| cpu_ready | output | 1 | Controller can accept a fetch, command or control write |
| rsp_valid | output | 1 | Fetch data valid |
| rsp_data | output | 32 | Fetched instruction word |
| cmd_valid | input | 1 | Line command strobe |
| cmd_op | input | 2 | 01 touch, 10 push, 11 push with invalidate, 00 none |
| cmd_addr | input | ADDR_W | Line command address |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 32 | Control value: bit 8 invalidate all, bit 11 lock |
| busy | output | 1 | Invalidate-all walk in progress |
| mem_req | output | 1 | Line refill request |
| mem_addr | output | ADDR_W | Line-aligned refill address |
| mem_ack | input | 1 | Single-cycle refill acknowledge |
| mem_line | input | 128 | Refill line, valid with `mem_ack` |

## Verification
The bound checker watches the protocol-level rules on every cycle. These are the hold and alignment of the refill request, the one-cycle hit response, the silence of `rsp_valid` and `cpu_ready` during the invalidate walk, the fact that a locked refill never targets ways 0 or 1, and the quiet state after reset.

Other behaviours are only visible over a sequence of operations, so only the bench scenarios show them. These include which line a miss evicts, whether preloaded lines survive further misses under lock, a touch that stays silent, and an invalidate that takes effect on the next fetch. The bench infers these from the hit-or-miss outcome of later fetches and from the refill count.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int OFF_W        = 4;
  localparam int LINE_W       = 128;
  localparam int WORD_W       = 32;
  localparam int CTL_INV_BIT  = 8;
  localparam int CTL_LOCK_BIT = 11;

  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_TOUCH    = 2'b01,
    OP_PUSH     = 2'b10,
    OP_PUSH_INV = 2'b11
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_REFILL = 2'b01,
    ST_FLUSH  = 2'b10
  } state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_row,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             kill_en,
  input  logic [WAY_W-1:0] kill_way,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic             wipe_en,
  input  logic [IDX_W-1:0] wipe_idx
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (wipe_en) valid_q[wipe_idx] <= '0;
      if (kill_en) valid_q[kill_idx][kill_way] <= 1'b0;
      if (fill_en) valid_q[fill_idx][fill_way] <= 1'b1;
    end
  end

  assign valid_row = valid_q[rd_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
  end
endmodule

// File: rtl/icache_data_ram.sv
module icache_data_ram #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [WAYS-1:0][LINE_W-1:0]  rd_line,
  input  logic                         wr_en,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [LINE_W-1:0]            wr_line
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] mem [SETS];
    logic [LINE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w)) mem[wr_idx] <= wr_line;
      rd_q <= mem[rd_idx];
    end
    assign rd_line[w] = rd_q;
  end
endmodule

// File: rtl/icache_victim.sv
module icache_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int LOCK_LO = WAYS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock,
  input  logic [WAYS-1:0]  valid_row,
  input  logic             advance,
  input  logic             clear,
  output logic [WAY_W-1:0] way,
  output logic             used_rr
);
  logic [WAY_W-1:0] rr_q;
  logic             found;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    found    = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w] && (!lock || w >= LOCK_LO)) begin
        found    = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    used_rr = !found;
    if (found)     way = free_way;
    else if (lock) way = WAY_W'(LOCK_LO) | (rr_q & WAY_W'(LOCK_LO - 1));
    else           way = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) rr_q <= '0;
    else if (advance) rr_q <= rr_q + 1'b1;
  end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [127:0]      mem_line
);
  state_e            state;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;
  logic [WAYS-1:0]   hit_vec, valid_row;
  logic              hit_any;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  vic_way;
  logic              vic_rr;
  logic              take_ctl, take_cmd, take_cpu, start_fill, kill_en;
  logic              refill_done, in_refill;
  logic              lock_q, touch_q, used_rr_q, from_ram_q;
  logic [IDX_W-1:0]  req_idx_q, flush_idx;
  logic [TAG_W-1:0]  req_tag_q;
  logic [WAY_W-1:0]  victim_q, hit_way_q;
  logic [1:0]        word_q;
  logic [31:0]       fill_word_q;
  logic [WAYS-1:0][LINE_W-1:0] ram_line;
  logic              ctl_unused;

  assign ctl_unused = ^{ctl_wdata, sel_addr[1:0]};

  assign sel_addr = cmd_valid ? cmd_addr : cpu_addr;
  assign sel_idx  = sel_addr[OFF_W +: IDX_W];
  assign sel_tag  = sel_addr[ADDR_W-1 -: TAG_W];

  assign cpu_ready = (state == ST_IDLE);
  assign busy      = (state == ST_FLUSH);
  assign in_refill = (state == ST_REFILL);

  assign take_ctl   = cpu_ready && ctl_we;
  assign take_cmd   = cpu_ready && !ctl_we && cmd_valid;
  assign take_cpu   = cpu_ready && !ctl_we && !cmd_valid && cpu_req;
  assign hit_any    = |hit_vec;
  assign start_fill = !hit_any && ((take_cmd && cmd_op == OP_TOUCH) || take_cpu);
  assign kill_en    = take_cmd && cmd_op == OP_PUSH_INV && hit_any;
  assign refill_done = in_refill && mem_ack;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  icache_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(sel_idx), .rd_tag(sel_tag),
    .hit_vec(hit_vec), .valid_row(valid_row),
    .fill_en(refill_done), .fill_way(victim_q), .fill_idx(req_idx_q), .fill_tag(req_tag_q),
    .kill_en(kill_en), .kill_way(hit_way), .kill_idx(sel_idx),
    .wipe_en(busy), .wipe_idx(flush_idx)
  );

  icache_data_ram #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rd_idx(sel_idx), .rd_line(ram_line),
    .wr_en(refill_done), .wr_way(victim_q), .wr_idx(req_idx_q), .wr_line(mem_line)
  );

  icache_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst(rst), .lock(lock_q), .valid_row(valid_row),
    .advance(refill_done && used_rr_q),
    .clear(take_ctl && ctl_wdata[CTL_INV_BIT]),
    .way(vic_way), .used_rr(vic_rr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      rsp_valid   <= 1'b0;
      lock_q      <= 1'b0;
      touch_q     <= 1'b0;
      used_rr_q   <= 1'b0;
      from_ram_q  <= 1'b0;
      req_idx_q   <= '0;
      req_tag_q   <= '0;
      flush_idx   <= '0;
      victim_q    <= '0;
      hit_way_q   <= '0;
      word_q      <= '0;
      fill_word_q <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take_ctl) begin
            lock_q <= ctl_wdata[CTL_LOCK_BIT];
            if (ctl_wdata[CTL_INV_BIT]) begin
              state     <= ST_FLUSH;
              flush_idx <= '0;
            end
          end else if (start_fill) begin
            state     <= ST_REFILL;
            mem_req   <= 1'b1;
            mem_addr  <= {sel_tag, sel_idx, {OFF_W{1'b0}}};
            req_idx_q <= sel_idx;
            req_tag_q <= sel_tag;
            victim_q  <= vic_way;
            used_rr_q <= vic_rr;
            touch_q   <= take_cmd;
            word_q    <= sel_addr[3:2];
          end else if (take_cpu) begin
            rsp_valid  <= 1'b1;
            from_ram_q <= 1'b1;
            hit_way_q  <= hit_way;
            word_q     <= sel_addr[3:2];
          end
        end
        ST_REFILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
            if (!touch_q) begin
              rsp_valid   <= 1'b1;
              from_ram_q  <= 1'b0;
              fill_word_q <= mem_line[{word_q, 5'b0} +: 32];
            end
          end
        end
        ST_FLUSH: begin
          flush_idx <= flush_idx + 1'b1;
          if (flush_idx == IDX_W'(SETS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_data = from_ram_q ? ram_line[hit_way_q][{word_q, 5'b0} +: 32] : fill_word_q;
endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              cmd_valid,
  input logic              ctl_we,
  input logic              rsp_valid,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              hit_any,
  input logic              lock_q,
  input logic              in_refill,
  input logic [WAY_W-1:0]  victim_q
);
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req); // R2
  AST_MEMADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> $stable(mem_addr)); // R2
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[3:0] == 4'd0); // R2
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ready && !ctl_we && !cmd_valid && hit_any |=> rsp_valid); // R1
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cpu_ready && !rsp_valid && !mem_req); // R5
  AST_LOCK_UPPER_WAYS: assert property (@(posedge clk) disable iff (rst)
    in_refill && lock_q |-> victim_q >= WAY_W'(WAYS / 2)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !mem_req && !rsp_valid && !busy && cpu_ready); // R9
endmodule

bind icache_ctrl icache_ctrl_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cmd_valid(cmd_valid), .ctl_we(ctl_we), .rsp_valid(rsp_valid), .busy(busy),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .hit_any(hit_any),
  .lock_q(lock_q), .in_refill(in_refill), .victim_q(victim_q)
);

// File: tb/tb_icache_ctrl.sv
`timescale 1ns/1ps
module tb_icache_ctrl;
  localparam int SETS = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic         cpu_ready, rsp_valid, busy, mem_req;
  logic [31:0]  rsp_data, mem_addr;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'b00;
  logic [31:0]  cmd_addr = '0;
  logic         ctl_we = 1'b0;
  logic [31:0]  ctl_wdata = '0;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_line = '0;

  icache_ctrl #(.ADDR_W(32), .WAYS(4), .SETS(SETS)) dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int refills = 0, rsp_seen = 0, rsp_cyc = 0, ack_cyc = 0;
  logic [31:0] last_fill = '0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  always @(posedge clk) cyc++;

  function automatic logic [31:0] word_of(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3C3_0000;
  endfunction

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // monitor: pop expected words as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      rsp_cyc = cyc;
      if (exp_q.size() == 0) check(1'b0, "R3", "unexpected response", rsp_data, 32'h0);
      else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(rsp_data === e, r, "response word", rsp_data, e);
      end
      rsp_seen++;
    end
  end

  // memory model: two-cycle latency, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req && !mem_ack) begin
        refills++;
        last_fill = mem_addr;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) mem_line[32*k +: 32] = word_of(mem_addr + 32'(4*k));
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        ack_cyc = cyc;
      end
    end
  end

  task automatic wait_ready();
    while (!cpu_ready) @(negedge clk);
  endtask

  task automatic do_read(logic [31:0] a, bit exp_hit, string rq);
    int r0, s0, g;
    wait_ready();
    r0 = refills; s0 = rsp_seen;
    exp_q.push_back(word_of(a)); req_q.push_back(rq);
    cpu_req = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    if (exp_hit) begin
      check(rsp_valid === 1'b1 && refills == r0, rq, "hit answered next cycle", 32'(rsp_valid), 32'h1);
    end
    g = 0;
    while (rsp_seen == s0 && g < 100) begin @(negedge clk); g++; end
    if (!exp_hit) begin
      check(refills == r0 + 1, rq, "miss refill count", 32'(refills - r0), 32'h1);
      check(last_fill == {a[31:4], 4'h0}, "R2", "refill line address", last_fill, {a[31:4], 4'h0});
      check(rsp_cyc == ack_cyc, "R2", "word cycle after ack", 32'(rsp_cyc), 32'(ack_cyc));
    end
    @(negedge clk);
  endtask

  task automatic do_cmd(logic [1:0] op, logic [31:0] a, int exp_fills, string rq);
    int r0, s0;
    wait_ready();
    r0 = refills; s0 = rsp_seen;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    wait_ready();
    repeat (2) @(negedge clk);
    check(refills == r0 + exp_fills, rq, "command refill count", 32'(refills - r0), 32'(exp_fills));
    check(rsp_seen == s0, rq, "command gives no response", 32'(rsp_seen - s0), 32'h0);
  endtask

  task automatic do_ctl(logic [31:0] v, int exp_busy, string rq);
    int n;
    bit rdy_bad;
    wait_ready();
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    n = 0; rdy_bad = 1'b0;
    while (busy && n < 1000) begin
      if (cpu_ready) rdy_bad = 1'b1;
      n++;
      @(negedge clk);
    end
    check(n == exp_busy, rq, "busy cycles", 32'(n), 32'(exp_busy));
    check(!rdy_bad, rq, "ready low while busy", 32'(rdy_bad), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R9", "watchdog expired", 32'(cyc), 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_ready === 1'b1 && busy === 1'b0, "R9", "ready/busy after reset", {busy, cpu_ready}, 32'h1);
    check(mem_req === 1'b0 && rsp_valid === 1'b0, "R9", "quiet after reset", {mem_req, rsp_valid}, 32'h0);

    // R2 miss, R1 hits on every word of the line
    do_read(32'h0000_1000, 1'b0, "R2");
    do_read(32'h0000_1004, 1'b1, "R1");
    do_read(32'h0000_100C, 1'b1, "R1");
    do_read(32'h0000_1008, 1'b1, "R1");
    do_read(32'h0000_1000, 1'b1, "R1");

    // R10: control write wins over a simultaneous fetch
    wait_ready();
    ctl_we = 1'b1; ctl_wdata = 32'h0; cpu_req = 1'b1; cpu_addr = 32'h0000_5000;
    @(negedge clk);
    ctl_we = 1'b0; cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    check(refills == 1 && rsp_seen == 5, "R10", "fetch dropped behind control write", 32'(refills), 32'h1);

    // R3 touch
    do_cmd(2'b01, 32'h0000_2000, 1, "R3");
    do_cmd(2'b01, 32'h0000_2000, 0, "R3");
    do_read(32'h0000_2004, 1'b1, "R3");

    // R4 push variants
    do_cmd(2'b10, 32'h0000_2000, 0, "R4");
    do_read(32'h0000_2008, 1'b1, "R4");
    do_cmd(2'b11, 32'h0000_2000, 0, "R4");
    do_read(32'h0000_200C, 1'b0, "R4");
    do_cmd(2'b11, 32'h0000_3000, 0, "R4");
    do_read(32'h0000_1004, 1'b1, "R4");

    // R5 invalidate all
    do_ctl(32'h0000_0100, SETS, "R5");
    do_read(32'h0000_1000, 1'b0, "R5");
    do_read(32'h0000_2000, 1'b0, "R5");

    // R7 replacement order in set 4
    do_ctl(32'h0000_0100, SETS, "R7");
    for (int k = 0; k < 4; k++) do_read(32'h0000_0040 + 32'(k) * 32'h1000, 1'b0, "R7");
    for (int k = 0; k < 4; k++) do_read(32'h0000_0040 + 32'(k) * 32'h1000, 1'b1, "R7");
    do_read(32'h0000_4040, 1'b0, "R7");
    do_read(32'h0000_1040, 1'b1, "R7");
    do_read(32'h0000_2040, 1'b1, "R7");
    do_read(32'h0000_3040, 1'b1, "R7");
    do_read(32'h0000_0040, 1'b0, "R7");
    do_read(32'h0000_2040, 1'b1, "R7");
    do_read(32'h0000_4040, 1'b1, "R7");
    do_read(32'h0000_1040, 1'b0, "R7");

    // R8 lock after preloading ways 0 and 1 of set 2
    do_ctl(32'h0000_0100, SETS, "R8");
    do_cmd(2'b01, 32'h0000_0020, 1, "R8");
    do_cmd(2'b01, 32'h0000_1020, 1, "R8");
    do_ctl(32'h0000_0800, 0, "R6");
    for (int k = 2; k < 7; k++) do_read(32'h0000_0020 + 32'(k) * 32'h1000, 1'b0, "R8");
    do_read(32'h0000_0024, 1'b1, "R8");
    do_read(32'h0000_1028, 1'b1, "R8");

    // R8 lock on a clean cache: empty lower ways stay empty
    do_ctl(32'h0000_0900, SETS, "R8");
    do_read(32'h0000_0030, 1'b0, "R8");
    do_read(32'h0000_1030, 1'b0, "R8");
    do_read(32'h0000_2030, 1'b0, "R8");
    do_read(32'h0000_0030, 1'b0, "R8");

    // R6 lock cleared: four lines of a set all stay resident
    do_ctl(32'h0000_0100, SETS, "R6");
    for (int k = 0; k < 4; k++) do_read(32'h0000_0050 + 32'(k) * 32'h1000, 1'b0, "R6");
    for (int k = 0; k < 4; k++) do_read(32'h0000_0050 + 32'(k) * 32'h1000, 1'b1, "R6");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R1", "all expected responses seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule